// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt

This block turns changes on a one-bit analog comparator output into a sticky interrupt flag. The raw comparator level is asynchronous. It is synchronized and then sampled once per four-clock instruction cycle, on a phase-0 enable. A second register holds the level that software saw at its last control-register access. The block compares the two, and the flag is set on the rising edge of the difference between them, not on the level of that difference.

Because the flag follows the edge, software can clear it without touching the control register. Suppose software clears the flag but never reads the control register. Each later departure of the sampled level from the held value then raises a new interrupt. A control-register read or write reloads the held value and so removes any pending difference. The flag can also be written directly. The interrupt request leaves the block only when three enables are all high.

Top module: `cmp_change_irq`

## Requirements
- R1: While reset is held low, and on the first clock after its release, `flagOut` and `irqOut` are 0.
- R2: The sampled level takes the synchronized input only on a phase-0 clock. These clocks come once every 4 clocks, starting with the first clock after reset. The input passes through 2 synchronizer stages first. If the input departs from the held value, the flag becomes 1 one clock after the sampled level changes.
- R3: Once set, the flag stays 1 until it is written with 0. Input changes and control-register accesses do not clear it.
- R4: A return of the sampled level to the held value never sets the flag. With no control-register access, every later departure from the held value sets the flag again, including departures after a software clear.
- R5: Both a control-register read (`ctlRead`) and a control-register write (`ctlWrite`) load the held value with the level being sampled. A difference that was pending before the access is then gone, so the next flag comes only from a departure from the newly held level.
- R6: A flag write (`flagWrEn`=1) loads `flagWrData` into the flag on the next clock. Writing 1 sets the flag and raises the interrupt.
- R7: If the hardware set and a flag write of 0 fall in the same clock, the flag becomes 1.
- R8: `irqOut` is 1 exactly when the flag, `chanEn`, `periphEn` and `globalEn` are all 1. The flag still sets while any enable is 0.
- R9: A control-register access in the same clock in which the sampled level changes loads the new level into the held value. No flag is set for that change. A later return to the old level then counts as a departure and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmpIn | input | 1 | Raw comparator output, asynchronous |
| ctlRead | input | 1 | Control-register read strobe |
| ctlWrite | input | 1 | Control-register write strobe; also reloads the held value |
| flagWrEn | input | 1 | Flag write strobe |
| flagWrData | input | 1 | Value written to the flag |
| chanEn | input | 1 | Channel interrupt enable |
| periphEn | input | 1 | Peripheral interrupt enable |
| globalEn | input | 1 | Global interrupt enable |
| flagOut | output | 1 | Sticky change flag |
| irqOut | output | 1 | Gated interrupt request |

## Verification
The hardest situation to reach is the race in R9. A register access has to land on the exact phase-0 clock in which a new synchronized level enters the sampling register. Random stimulus seldom hits that one clock. The bench therefore steers the access from its behavioural model: it watches the model's delay line and phase counter, and raises `ctlRead` in the one cycle where the sampled level is about to change. The R7 collision is reached the same way, with a flag write of 0 placed on the clock the model predicts for the hardware set.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
  // Strobes handed from control to datapath each clock
  typedef struct packed {
    logic sampleEn;  // phase-0 sampling enable
    logic snapLoad;  // control-register access reloads the held value
  } strobe_t;
endpackage

// File: rtl/cmpirq_ctrl.sv
module cmpirq_ctrl
  import cmpirq_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctlRead,
  input  logic    ctlWrite,
  input  logic    hwSet,
  input  logic    flagWrEn,
  input  logic    flagWrData,
  input  logic    chanEn,
  input  logic    periphEn,
  input  logic    globalEn,
  output strobe_t strb,
  output logic    flagQ,
  output logic    irqOut
);
  localparam int PHASE_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PHASES - 1);

  logic [PHASE_W-1:0] phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (phaseQ == LAST_PHASE) begin
      phaseQ <= '0;
    end else begin
      phaseQ <= phaseQ + 1'b1;
    end
  end

  always_comb begin
    strb.sampleEn = (phaseQ == '0);
    strb.snapLoad = ctlRead | ctlWrite;
  end

  // Hardware set outranks a software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (hwSet) begin
      flagQ <= 1'b1;
    end else if (flagWrEn) begin
      flagQ <= flagWrData;
    end
  end

  assign irqOut = flagQ & chanEn & periphEn & globalEn;
endmodule

// File: rtl/cmpirq_dp.sv
module cmpirq_dp
  import cmpirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmpIn,
  input  strobe_t strb,
  output logic    sampleQ,
  output logic    mismatch,
  output logic    hwSet
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic syncOut;
  logic sampleNext;
  logic snapQ;
  logic mismPrevQ;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= cmpIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign syncOut    = syncQ[SYNC_STAGES-1];
  assign sampleNext = strb.sampleEn ? syncOut : sampleQ;

  // The held value takes the level entering the sampler, so an access
  // in the sampling clock keeps the new level and no difference appears.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleQ   <= 1'b0;
      snapQ     <= 1'b0;
      mismPrevQ <= 1'b0;
    end else begin
      sampleQ   <= sampleNext;
      mismPrevQ <= mismatch;
      if (strb.snapLoad) snapQ <= sampleNext;
    end
  end

  assign mismatch = snapQ ^ sampleQ;
  assign hwSet    = mismatch & ~mismPrevQ;
endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
  import cmpirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PHASES      = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmpIn,
  input  logic ctlRead,
  input  logic ctlWrite,
  input  logic flagWrEn,
  input  logic flagWrData,
  input  logic chanEn,
  input  logic periphEn,
  input  logic globalEn,
  output logic flagOut,
  output logic irqOut
);
  strobe_t strb;
  logic sampleQ;
  logic sampleEn;
  logic mismatch;
  logic hwSet;

  assign sampleEn = strb.sampleEn;

  cmpirq_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlRead(ctlRead), .ctlWrite(ctlWrite),
    .hwSet(hwSet), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .chanEn(chanEn), .periphEn(periphEn), .globalEn(globalEn),
    .strb(strb), .flagQ(flagOut), .irqOut(irqOut)
  );

  cmpirq_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .strb(strb),
    .sampleQ(sampleQ), .mismatch(mismatch), .hwSet(hwSet)
  );
endmodule

// File: rtl/cmp_change_irq_chk.sv
module cmp_change_irq_chk (
  input logic clk,
  input logic rstN,
  input logic ctlRead,
  input logic ctlWrite,
  input logic flagWrEn,
  input logic flagWrData,
  input logic flagOut,
  input logic mismatch,
  input logic sampleQ,
  input logic sampleEn
);
  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mismatch) |=> flagOut); // R2

  AST_SAMPLE_ON_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(sampleQ)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagOut && !flagWrEn) |=> flagOut); // R3

  AST_RETURN_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mismatch) && !flagOut && !flagWrEn) |=> !flagOut); // R4

  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRead || ctlWrite) |=> !mismatch); // R5

  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && !flagWrData && !$rose(mismatch)) |=> !flagOut); // R6

  AST_WRITE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && flagWrData) |=> flagOut); // R6

  AST_HW_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && !flagWrData && $rose(mismatch)) |=> flagOut); // R7
endmodule

bind cmp_change_irq cmp_change_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .ctlRead(ctlRead), .ctlWrite(ctlWrite),
  .flagWrEn(flagWrEn), .flagWrData(flagWrData), .flagOut(flagOut),
  .mismatch(mismatch), .sampleQ(sampleQ), .sampleEn(sampleEn)
);

// File: tb/sim_cmp_change_irq.sv
`timescale 1ns/1ps
module sim_cmp_change_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpIn = 1'b0, ctlRead = 1'b0, ctlWrite = 1'b0;
  logic flagWrEn = 1'b0, flagWrData = 1'b0;
  logic chanEn = 1'b0, periphEn = 1'b0, globalEn = 1'b0;
  logic flagOut, irqOut;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  cmp_change_irq u0 (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .ctlRead(ctlRead),
    .ctlWrite(ctlWrite), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .chanEn(chanEn), .periphEn(periphEn), .globalEn(globalEn),
    .flagOut(flagOut), .irqOut(irqOut)
  );

  // Behavioural reference: delay line, phase count, held and sampled levels
  bit dly[$] = '{1'b0, 1'b0};
  int mPhase = 0;
  bit mSample = 0, mHeld = 0, mPrevDiff = 0, mFlag = 0;

  task automatic chk(string req, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      dly = '{1'b0, 1'b0};
      mPhase = 0; mSample = 0; mHeld = 0; mPrevDiff = 0; mFlag = 0;
    end else begin
      bit diff, rise, nextSample;
      diff = mHeld ^ mSample;
      rise = diff && !mPrevDiff;
      nextSample = (mPhase == 0) ? dly[0] : mSample;
      mPrevDiff = diff;
      if (rise) mFlag = 1;
      else if (flagWrEn) mFlag = flagWrData;
      if (ctlRead || ctlWrite) mHeld = nextSample;
      mSample = nextSample;
      void'(dly.pop_front());
      dly.push_back(cmpIn);
      mPhase = (mPhase + 1) % 4;
    end
    #1;
    chk(curReq, flagOut, mFlag, "flag vs model");
    chk(curReq, irqOut, mFlag & chanEn & periphEn & globalEn, "irq vs model");
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic wrFlag(logic v);
    flagWrData = v; flagWrEn = 1'b1; cyc(1); flagWrEn = 1'b0; flagWrData = 1'b0;
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(3);
    chk("R1", flagOut, 1'b0, "flag in reset");
    chk("R1", irqOut, 1'b0, "irq in reset");
    rstN = 1'b1;
    cyc(1);
    chk("R1", flagOut, 1'b0, "flag after reset");
    chanEn = 1; periphEn = 1; globalEn = 1;
    cyc(2);

    // R2: departure sets flag after sync and phase-0 sampling
    curReq = "R2";
    cmpIn = 1'b1;
    cyc(2);
    chk("R2", flagOut, 1'b0, "flag before sync latency");
    cyc(7);
    chk("R2", flagOut, 1'b1, "flag after departure");
    chk("R2", irqOut, 1'b1, "irq after departure");

    // R3: sticky
    curReq = "R3";
    cyc(10);
    chk("R3", flagOut, 1'b1, "flag still set");
    pulse(ctlRead);
    cyc(3);
    chk("R3", flagOut, 1'b1, "flag survives read");

    // R6: software write
    curReq = "R6";
    wrFlag(1'b0);
    chk("R6", flagOut, 1'b0, "write 0 clears");
    wrFlag(1'b1);
    chk("R6", flagOut, 1'b1, "write 1 sets");
    chk("R6", irqOut, 1'b1, "write 1 raises irq");
    wrFlag(1'b0);

    // R4: return to held value (held=1 now) never sets; repeated departures do
    curReq = "R4";
    cmpIn = 1'b0; cyc(10);
    chk("R4", flagOut, 1'b1, "departure to 0 sets");
    wrFlag(1'b0);
    cmpIn = 1'b1; cyc(10);
    chk("R4", flagOut, 1'b0, "return to held level no set");
    cmpIn = 1'b0; cyc(10);
    chk("R4", flagOut, 1'b1, "second departure sets again");
    wrFlag(1'b0);

    // R5: read and write reload the held value
    curReq = "R5";
    pulse(ctlRead); cyc(4);           // held = 0
    cmpIn = 1'b1; cyc(10);
    chk("R5", flagOut, 1'b1, "departure from read level");
    wrFlag(1'b0);
    pulse(ctlWrite); cyc(4);          // held = 1 via write
    cmpIn = 1'b1; cyc(10);
    chk("R5", flagOut, 1'b0, "no flag at written level");
    cmpIn = 1'b0; cyc(10);
    chk("R5", flagOut, 1'b1, "departure from written level");
    wrFlag(1'b0);
    pulse(ctlRead); cyc(4);           // held = 0

    // R7: hardware set vs write 0 in the same clock
    curReq = "R7";
    cmpIn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if ((mHeld ^ mSample) && !mPrevDiff) break;
      cyc(1);
    end
    wrFlag(1'b0);
    chk("R7", flagOut, 1'b1, "hardware set wins");
    wrFlag(1'b0);
    pulse(ctlRead); cyc(4);           // held = 1

    // R8: enable gating
    curReq = "R8";
    wrFlag(1'b1);
    chanEn = 0; cyc(1);
    chk("R8", irqOut, 1'b0, "chanEn low gates");
    chanEn = 1; periphEn = 0; cyc(1);
    chk("R8", irqOut, 1'b0, "periphEn low gates");
    periphEn = 1; globalEn = 0; cyc(1);
    chk("R8", irqOut, 1'b0, "globalEn low gates");
    wrFlag(1'b0);
    chanEn = 0; periphEn = 0;
    cmpIn = 1'b0; cyc(10);
    chk("R8", flagOut, 1'b1, "flag sets with enables low");
    chk("R8", irqOut, 1'b0, "irq stays low");
    chanEn = 1; periphEn = 1; globalEn = 1; cyc(1);
    chk("R8", irqOut, 1'b1, "irq once all enables high");
    wrFlag(1'b0);
    pulse(ctlRead); cyc(4);           // held = 0

    // R9: access on the sampling clock of a change
    curReq = "R9";
    cmpIn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (mPhase == 0 && dly[0] != mSample) break;
      cyc(1);
    end
    pulse(ctlRead);
    cyc(10);
    chk("R9", flagOut, 1'b0, "race read suppresses flag");
    cmpIn = 1'b0; cyc(10);
    chk("R9", flagOut, 1'b1, "held took new level");
    wrFlag(1'b0);
    cyc(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule